// File: doc/BRIEF.md
# Deferred Machine-Check Error Tracker

This block sits beside the in-order retirement stage of a speculative core and keeps a small status word for each instruction still in flight. Instructions take tags from a circular window of eight slots, in program order. When the memory side reports an uncorrectable ECC error for a load, the block does not stop the machine. It marks the load's slot. The machine check is raised only when that load reaches retirement, so the check is precise and points at the faulting instruction.

A branch mispredict discards every slot younger than the branch. An error on such a wrong-path slot is dropped by default. If the squash-raise control input is high, the flush itself raises an imprecise machine check tagged with the branch. Errors reported after an instruction has already retired, such as a buffered store draining to memory, arrive on a separate input and always raise an imprecise check. Two saturating counters keep separate totals of precise and imprecise machine checks.

Top module: `mdc_tracker`

## Requirements
- R1: In reset and in the first cycle after it, `mce_req_o`, `mce_precise_o`, `mce_tag_o` and both counters read zero, and every slot is empty.
- R2: An error report for a tag in flight marks that slot and raises no machine check of its own.
- R3: Retiring the oldest slot while it is marked raises `mce_req_o` with `mce_precise_o`=1 and `mce_tag_o` equal to that tag in the cycle after the retire edge, and adds one to `precise_cnt_o` at that same edge.
- R4: Retiring an unmarked slot raises no machine check.
- R5: A flush with a branch tag in flight empties every slot younger than the branch; allocation resumes at the tag after the branch. With `squash_raise_en_i`=0, marked slots discarded this way raise nothing and change no counter, and a reused tag starts unmarked.
- R6: A flush with `squash_raise_en_i`=1 that discards at least one marked slot raises an imprecise check (`mce_precise_o`=0) with `mce_tag_o` equal to the branch tag and adds one to `imprecise_cnt_o`. If no discarded slot is marked, nothing is raised.
- R7: A post-retirement error report raises an imprecise check carrying the reported tag and adds one to `imprecise_cnt_o`.
- R8: An error report for a tag that is not in flight has no effect. A later retire of that tag raises nothing.
- R9: When events coincide, the reported check is chosen in this order: retire, then flush, then post-retirement. Each counter still counts its own event, at most one step per cycle.
- R10: Both counters stop at their all-ones value and never wrap.
- R11: An error reported for the oldest slot in the same cycle as its retire counts as a mark, and that retire raises a precise check.
- R12: Tags wrap modulo 8. Slot order is reckoned from the oldest tag, so age comparisons stay correct across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_i | input | 1 | Allocate the next tag to a new instruction (ignored during a flush or when full) |
| retire_i | input | 1 | Retire the oldest instruction in flight |
| err_vld_i | input | 1 | Uncorrectable load error report is valid |
| err_tag_i | input | 3 | Tag of the load that took the error |
| flush_i | input | 1 | Branch mispredict flush |
| flush_tag_i | input | 3 | Tag of the mispredicting branch |
| squash_raise_en_i | input | 1 | Raise a check when marked slots are squashed |
| late_err_vld_i | input | 1 | Post-retirement error report is valid |
| late_err_tag_i | input | 3 | Tag carried by the post-retirement report |
| mce_req_o | output | 1 | Machine-check request, one-cycle pulse |
| mce_precise_o | output | 1 | The request is precise |
| mce_tag_o | output | 3 | Tag attached to the request |
| precise_cnt_o | output | CNT_W | Saturating count of precise checks |
| imprecise_cnt_o | output | CNT_W | Saturating count of imprecise checks |

## Verification
Each outcome is registered once. A retire, flush or late report presented before a rising edge shows up on `mce_req_o`, `mce_precise_o` and `mce_tag_o`, and in the counters, right after that edge. The result lasts one cycle. The bench drives inputs on the falling edge and checks the outputs on the next falling edge, one cycle later, for every row of its table. A mark is invisible until its retire, so the deferred-error cases check that `mce_req_o` stays low in the report cycle and then check the retire cycle. The ignored and dropped cases are checked by retiring the affected tags later and seeing no request.

// File: rtl/mdc_pkg.sv
// Package: shared types for the deferred machine-check tracker.
// Assumes: the window depth is a power of two, so tags wrap naturally.
package mdc_pkg;

    localparam int unsigned MDC_DEPTH = 8;
    localparam int unsigned MDC_TAG_W = $clog2(MDC_DEPTH);

    // Source that produced a reported machine check, in priority order
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_RETIRE = 2'd1,
        SRC_SQUASH = 2'd2,
        SRC_LATE   = 2'd3
    } mce_src_e;

    // One registered machine-check report
    typedef struct packed {
        logic                 req;
        logic                 precise;
        logic [MDC_TAG_W-1:0] tag;
    } mce_rpt_t;

endpackage

// File: rtl/mdc_status_array.sv
// Module: mdc_status_array
// Holds one valid bit and one error mark per in-flight tag. Tags are handed
// out in order from tail and retired in order from head. Ages are measured
// from head, which keeps comparisons right when the tags wrap.
// Assumes: DEPTH is a power of two. Upstream never allocates into a full
// window and does not allocate in a flush cycle (such requests are ignored).
module mdc_status_array #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned TAG_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_i,
    input  logic             retire_i,
    input  logic             err_vld_i,
    input  logic [TAG_W-1:0] err_tag_i,
    input  logic             flush_i,
    input  logic [TAG_W-1:0] flush_tag_i,
    output logic             ret_hit_o,
    output logic [TAG_W-1:0] ret_tag_o,
    output logic             sq_marked_o
);

    localparam int unsigned CNT_W = TAG_W + 1;

    logic [DEPTH-1:0] valid_q, marked_q;
    logic [DEPTH-1:0] valid_d, marked_d;
    logic [DEPTH-1:0] eff_mark, squash_vec;
    logic [TAG_W-1:0] head_q, tail_q, head_d, tail_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic [TAG_W-1:0] br_age;
    logic             retire_ok, flush_ok, alloc_ok, err_hit;

    // Qualify the incoming events against the current window
    always_comb begin
        retire_ok = retire_i && (count_q != '0);
        flush_ok  = flush_i && valid_q[flush_tag_i];
        alloc_ok  = alloc_i && !flush_i && (count_q < CNT_W'(DEPTH));
        err_hit   = err_vld_i && valid_q[err_tag_i];
        br_age    = flush_tag_i - head_q;
    end

    // Per-slot mark merge, squash decision and next state
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        logic [TAG_W-1:0] my_age;
        always_comb begin
            my_age         = TAG_W'(gi) - head_q;
            eff_mark[gi]   = marked_q[gi] || (err_hit && (err_tag_i == TAG_W'(gi)));
            squash_vec[gi] = flush_ok && valid_q[gi] && (my_age > br_age);
            if (squash_vec[gi] || (retire_ok && head_q == TAG_W'(gi))) begin
                valid_d[gi]  = 1'b0;
                marked_d[gi] = 1'b0;
            end else if (alloc_ok && tail_q == TAG_W'(gi)) begin
                valid_d[gi]  = 1'b1;
                marked_d[gi] = 1'b0;
            end else begin
                valid_d[gi]  = valid_q[gi];
                marked_d[gi] = eff_mark[gi] && valid_q[gi];
            end
        end
    end

    // Pointer and occupancy update
    always_comb begin
        head_d  = retire_ok ? head_q + 1'b1 : head_q;
        tail_d  = tail_q;
        count_d = count_q;
        if (flush_ok) begin
            tail_d  = flush_tag_i + 1'b1;
            count_d = CNT_W'(br_age) + 1'b1 - CNT_W'(retire_ok);
        end else begin
            if (alloc_ok) tail_d = tail_q + 1'b1;
            count_d = count_q + CNT_W'(alloc_ok) - CNT_W'(retire_ok);
        end
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= '0;
            marked_q <= '0;
            head_q   <= '0;
            tail_q   <= '0;
            count_q  <= '0;
        end else begin
            valid_q  <= valid_d;
            marked_q <= marked_d;
            head_q   <= head_d;
            tail_q   <= tail_d;
            count_q  <= count_d;
        end
    end

    // Report the retire and squash outcomes to the raise logic
    always_comb begin
        ret_hit_o   = retire_ok && eff_mark[head_q];
        ret_tag_o   = head_q;
        sq_marked_o = |(squash_vec & eff_mark);
    end

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH)); // R12

    AST_RETIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        retire_ok |=> !valid_q[$past(head_q)] && !marked_q[$past(head_q)]); // R3

    AST_MARK_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (marked_q & ~valid_q) == '0); // R8

    AST_FLUSH_KEEPS_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        flush_ok && !(retire_ok && head_q == flush_tag_i) |=> valid_q[$past(flush_tag_i)]); // R5

endmodule

// File: rtl/mdc_raise_sel.sv
// Module: mdc_raise_sel
// Picks the one machine check to report in a cycle (retire, then squash,
// then post-retirement) and registers it as a one-cycle pulse. It also
// produces the per-counter increment strobes.
// Assumes: the hit inputs are already qualified by the status array.
module mdc_raise_sel
    import mdc_pkg::*;
#(
    parameter int unsigned TAG_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ret_hit_i,
    input  logic [TAG_W-1:0] ret_tag_i,
    input  logic             sq_marked_i,
    input  logic             sq_raise_en_i,
    input  logic [TAG_W-1:0] flush_tag_i,
    input  logic             late_vld_i,
    input  logic [TAG_W-1:0] late_tag_i,
    output logic             req_o,
    output logic             precise_o,
    output logic [TAG_W-1:0] tag_o,
    output logic             inc_precise_o,
    output logic             inc_imprecise_o
);

    mce_src_e         src;
    logic             sq_hit;
    logic [TAG_W-1:0] sel_tag;
    logic             req_q, precise_q;
    logic [TAG_W-1:0] tag_q;

    // Choose the reporting source by fixed priority
    always_comb begin
        sq_hit = sq_marked_i && sq_raise_en_i;
        if (ret_hit_i)       src = SRC_RETIRE;
        else if (sq_hit)     src = SRC_SQUASH;
        else if (late_vld_i) src = SRC_LATE;
        else                 src = SRC_NONE;
        case (src)
            SRC_RETIRE: sel_tag = ret_tag_i;
            SRC_SQUASH: sel_tag = flush_tag_i;
            SRC_LATE:   sel_tag = late_tag_i;
            default:    sel_tag = '0;
        endcase
        inc_precise_o   = ret_hit_i;
        inc_imprecise_o = sq_hit || late_vld_i;
    end

    // Register the selected report as a single-cycle pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q     <= 1'b0;
            precise_q <= 1'b0;
            tag_q     <= '0;
        end else begin
            req_q     <= (src != SRC_NONE);
            precise_q <= (src == SRC_RETIRE);
            tag_q     <= sel_tag;
        end
    end

    assign req_o     = req_q;
    assign precise_o = precise_q;
    assign tag_o     = tag_q;

    AST_PRECISE_IMPLIES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        precise_q |-> req_q); // R3

    AST_RETIRE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ret_hit_i |=> req_q && precise_q && tag_q == $past(ret_tag_i)); // R9

    AST_LATE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        late_vld_i |=> req_q); // R7

endmodule

// File: rtl/mdc_sat_counter.sv
// Module: mdc_sat_counter
// Event counter that holds at its all-ones value instead of wrapping.
// Assumes: at most one increment per cycle.
module mdc_sat_counter #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    output logic [WIDTH-1:0] cnt_o
);

    localparam logic [WIDTH-1:0] MAX_V = '1;

    logic [WIDTH-1:0] cnt_q;

    // Count up on each strobe until the ceiling is reached
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (inc_i && cnt_q != MAX_V) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q == MAX_V |=> cnt_q == MAX_V); // R10

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_i |=> $stable(cnt_q)); // R10

endmodule

// File: rtl/mdc_tracker.sv
// Module: mdc_tracker (top)
// Deferred machine-check tracker. Load errors are stored as marks on
// in-flight tags and raised precisely at retire. Squashed marks are dropped,
// or raised imprecisely at the flush when enabled. Post-retirement reports
// are always imprecise. Precise and imprecise totals saturate.
// Assumes: in-order retirement from the oldest tag, in-order allocation.
module mdc_tracker
    import mdc_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc_i,
    input  logic                 retire_i,
    input  logic                 err_vld_i,
    input  logic [MDC_TAG_W-1:0] err_tag_i,
    input  logic                 flush_i,
    input  logic [MDC_TAG_W-1:0] flush_tag_i,
    input  logic                 squash_raise_en_i,
    input  logic                 late_err_vld_i,
    input  logic [MDC_TAG_W-1:0] late_err_tag_i,
    output logic                 mce_req_o,
    output logic                 mce_precise_o,
    output logic [MDC_TAG_W-1:0] mce_tag_o,
    output logic [CNT_W-1:0]     precise_cnt_o,
    output logic [CNT_W-1:0]     imprecise_cnt_o
);

    logic                 ret_hit, sq_marked, inc_p, inc_i;
    logic [MDC_TAG_W-1:0] ret_tag;
    mce_rpt_t             rpt;

    mdc_status_array #(.DEPTH(MDC_DEPTH), .TAG_W(MDC_TAG_W)) i_array (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_i     (alloc_i),
        .retire_i    (retire_i),
        .err_vld_i   (err_vld_i),
        .err_tag_i   (err_tag_i),
        .flush_i     (flush_i),
        .flush_tag_i (flush_tag_i),
        .ret_hit_o   (ret_hit),
        .ret_tag_o   (ret_tag),
        .sq_marked_o (sq_marked)
    );

    mdc_raise_sel #(.TAG_W(MDC_TAG_W)) i_raise (
        .clk             (clk),
        .rst_n           (rst_n),
        .ret_hit_i       (ret_hit),
        .ret_tag_i       (ret_tag),
        .sq_marked_i     (sq_marked),
        .sq_raise_en_i   (squash_raise_en_i),
        .flush_tag_i     (flush_tag_i),
        .late_vld_i      (late_err_vld_i),
        .late_tag_i      (late_err_tag_i),
        .req_o           (rpt.req),
        .precise_o       (rpt.precise),
        .tag_o           (rpt.tag),
        .inc_precise_o   (inc_p),
        .inc_imprecise_o (inc_i)
    );

    // One saturating counter per error class
    for (genvar gc = 0; gc < 2; gc++) begin : g_cnt
        logic [CNT_W-1:0] cnt;
        mdc_sat_counter #(.WIDTH(CNT_W)) i_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc_i ((gc == 0) ? inc_p : inc_i),
            .cnt_o (cnt)
        );
    end

    assign precise_cnt_o   = g_cnt[0].cnt;
    assign imprecise_cnt_o = g_cnt[1].cnt;
    assign mce_req_o       = rpt.req;
    assign mce_precise_o   = rpt.precise;
    assign mce_tag_o       = rpt.tag;

    AST_ERR_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
        err_vld_i && !retire_i && !flush_i && !late_err_vld_i |=> !mce_req_o); // R2

    AST_SQUASH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i && !squash_raise_en_i && !retire_i && !late_err_vld_i |=> !mce_req_o); // R5

    AST_IMPRECISE_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        mce_req_o && !mce_precise_o |-> imprecise_cnt_o != '0); // R6

endmodule

// File: tb/test_mdc_tracker.sv
// Bench for mdc_tracker: a table of one-cycle stimulus rows with expected
// outputs, then directed reset, squash and saturation cases.
module test_mdc_tracker;

    localparam int CW = 4;

    typedef struct packed {
        logic       al, rt, ev;
        logic [2:0] et;
        logic       fl;
        logic [2:0] ft;
        logic       rs, lv;
        logic [2:0] lt;
        logic       xr, xp;
        logic [2:0] xt;
        logic [3:0] xpc, xic;
        logic [3:0] rq;
    } vec_t;

    function automatic vec_t mk(int al, int rt, int ev, int et, int fl, int ft,
                                int rs, int lv, int lt, int xr, int xp, int xt,
                                int xpc, int xic, int rq);
        vec_t v;
        v.al = al[0]; v.rt = rt[0]; v.ev = ev[0]; v.et = et[2:0];
        v.fl = fl[0]; v.ft = ft[2:0]; v.rs = rs[0]; v.lv = lv[0];
        v.lt = lt[2:0]; v.xr = xr[0]; v.xp = xp[0]; v.xt = xt[2:0];
        v.xpc = xpc[3:0]; v.xic = xic[3:0]; v.rq = rq[3:0];
        return v;
    endfunction

    // al rt ev et fl ft rs lv lt | xr xp xt pc ic | req
    localparam vec_t VECS [30] = '{
        mk(1,0,0,0, 0,0,0, 0,0,  0,0,0, 0,0, 12), // alloc tag0
        mk(1,0,0,0, 0,0,0, 0,0,  0,0,0, 0,0, 12), // tag1
        mk(1,0,0,0, 0,0,0, 0,0,  0,0,0, 0,0, 12), // tag2
        mk(1,0,0,0, 0,0,0, 0,0,  0,0,0, 0,0, 12), // tag3
        mk(0,0,1,1, 0,0,0, 0,0,  0,0,0, 0,0,  2), // R2 mark tag1, no raise
        mk(0,1,0,0, 0,0,0, 0,0,  0,0,0, 0,0,  4), // R4 retire unmarked tag0
        mk(0,1,0,0, 0,0,0, 0,0,  1,1,1, 1,0,  3), // R3 retire marked tag1
        mk(0,0,1,3, 0,0,0, 0,0,  0,0,0, 1,0,  2), // mark tag3
        mk(0,0,0,0, 1,2,0, 0,0,  0,0,0, 1,0,  5), // R5 flush at 2, drop tag3
        mk(1,0,0,0, 0,0,0, 0,0,  0,0,0, 1,0,  5), // reuse tag3
        mk(0,1,0,0, 0,0,0, 0,0,  0,0,0, 1,0,  5), // retire tag2
        mk(0,1,0,0, 0,0,0, 0,0,  0,0,0, 1,0,  5), // retire tag3 clean
        mk(1,0,0,0, 0,0,0, 0,0,  0,0,0, 1,0, 12), // tag4
        mk(1,0,0,0, 0,0,0, 0,0,  0,0,0, 1,0, 12), // tag5
        mk(0,0,1,5, 0,0,0, 0,0,  0,0,0, 1,0,  2), // mark tag5
        mk(0,0,0,0, 1,4,1, 0,0,  1,0,4, 1,1,  6), // R6 squash raise, branch tag4
        mk(0,0,0,0, 0,0,0, 1,6,  1,0,6, 1,2,  7), // R7 late report tag6
        mk(0,0,1,7, 0,0,0, 0,0,  0,0,0, 1,2,  8), // R8 tag7 not in flight
        mk(1,0,0,0, 0,0,0, 0,0,  0,0,0, 1,2, 12), // tag5
        mk(1,0,0,0, 0,0,0, 0,0,  0,0,0, 1,2, 12), // tag6
        mk(1,0,0,0, 0,0,0, 0,0,  0,0,0, 1,2, 12), // tag7
        mk(0,1,0,0, 0,0,0, 0,0,  0,0,0, 1,2,  5), // retire tag4
        mk(0,1,0,0, 0,0,0, 0,0,  0,0,0, 1,2,  5), // retire tag5 (mark gone)
        mk(0,1,0,0, 0,0,0, 0,0,  0,0,0, 1,2,  8), // retire tag6
        mk(0,1,0,0, 0,0,0, 0,0,  0,0,0, 1,2,  8), // R8 retire tag7 silent
        mk(1,0,0,0, 0,0,0, 0,0,  0,0,0, 1,2, 12), // R12 wrap to tag0
        mk(0,1,1,0, 0,0,0, 0,0,  1,1,0, 2,2, 11), // R11 same-cycle mark+retire
        mk(1,0,0,0, 0,0,0, 0,0,  0,0,0, 2,2, 12), // tag1
        mk(0,0,1,1, 0,0,0, 0,0,  0,0,0, 2,2,  2), // mark tag1
        mk(0,1,0,0, 0,0,0, 1,5,  1,1,1, 3,3,  9)  // R9 retire beats late
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alloc, retire, ev, fl, rs, lv;
    logic [2:0] et, ft, lt;
    logic       req, prec;
    logic [2:0] tag;
    logic [CW-1:0] pcnt, icnt;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mdc_tracker #(.CNT_W(CW)) i_mdc_tracker (
        .clk (clk), .rst_n (rst_n), .alloc_i (alloc), .retire_i (retire),
        .err_vld_i (ev), .err_tag_i (et), .flush_i (fl), .flush_tag_i (ft),
        .squash_raise_en_i (rs), .late_err_vld_i (lv), .late_err_tag_i (lt),
        .mce_req_o (req), .mce_precise_o (prec), .mce_tag_o (tag),
        .precise_cnt_o (pcnt), .imprecise_cnt_o (icnt)
    );

    task automatic drive(vec_t v);
        alloc = v.al; retire = v.rt; ev = v.ev; et = v.et; fl = v.fl;
        ft = v.ft; rs = v.rs; lv = v.lv; lt = v.lt;
    endtask

    task automatic idle();
        drive(mk(0,0,0,0, 0,0,0, 0,0, 0,0,0, 0,0, 0));
    endtask

    task automatic check(string rq, logic xr, logic xp, logic [2:0] xt,
                         logic [3:0] xpc, logic [3:0] xic);
        checks++;
        if (req !== xr || prec !== xp || (xr && tag !== xt) ||
            pcnt !== xpc || icnt !== xic) begin
            errors++;
            $display("FAIL %s: got req=%0b prec=%0b tag=%0d pc=%0d ic=%0d, expected req=%0b prec=%0b tag=%0d pc=%0d ic=%0d",
                     rq, req, prec, tag, pcnt, icnt, xr, xp, xt, xpc, xic);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        check("R1 in reset", 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 0, 0, 0, 0, 0);

        for (int i = 0; i < 30; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            check($sformatf("R%0d table row %0d", VECS[i].rq, i),
                  VECS[i].xr, VECS[i].xp, VECS[i].xt, VECS[i].xpc, VECS[i].xic);
        end

        // R6 flush with raise enabled but no marked younger slot: silent
        drive(mk(1,0,0,0, 0,0,0, 0,0, 0,0,0, 0,0, 0)); @(negedge clk); // tag2
        drive(mk(1,0,0,0, 0,0,0, 0,0, 0,0,0, 0,0, 0)); @(negedge clk); // tag3
        drive(mk(0,0,0,0, 1,2,1, 0,0, 0,0,0, 0,0, 0)); @(negedge clk);
        check("R6 unmarked squash", 0, 0, 0, 3, 3);

        // R10 imprecise counter stops at 15
        for (int k = 0; k < 14; k++) begin
            drive(mk(0,0,0,0, 0,0,0, 1,3, 0,0,0, 0,0, 0));
            @(negedge clk);
        end
        check("R10 saturated", 1, 0, 3, 3, 15);
        idle();
        @(negedge clk);
        check("R10 hold", 0, 0, 0, 3, 15);

        // R1 reset in mid-run clears the counters
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 mid-run reset", 0, 0, 0, 0, 0);

        finish_run();
    end

endmodule